// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into a target programmable device over a two-wire passive serial link. It first asks the target to clear itself by pulling an active-low request line. It then checks that the target's active-low status line answers with a reset, releases the request, and polls the status line until the target says it is ready. After a short settle time it accepts bitstream bytes from a valid/ready stream with a last flag. Each byte goes out one bit at a time on a data line, qualified by a serial clock that it generates itself.

Once the last byte has been sent, the loader checks the status line and, if that pin exists, the configuration-done input. A clean check is followed by eight extra serial clocks carrying zeros, which let the target start up. The result is reported as a done flag or as a two-bit error code, and both stay as they are until the next start. All device timing limits are given in microseconds and scaled by a clock-frequency parameter. A profile parameter picks between a default device and a large device.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset the request line `cfg_req_n_o` is high, `dclk_o`, `busy_o`, `done_o` and `s_ready_o` are low, and `err_o` is 0.
- R2: A start pulse that is not flagged partial drives `cfg_req_n_o` low for exactly REQ_US*CLK_MHZ clock cycles and then releases it. The line only goes low in the cycle after a start.
- R3: If `status_n_i` is still high at the end of the request pulse, the load aborts with error code 2 (target not responding). No byte is requested and busy drops.
- R4: After release, `status_n_i` is sampled once every POLL_US*CLK_MHZ cycles. The first sample that reads high starts a settle wait of SETTLE_US*CLK_MHZ cycles, where SETTLE_US is 2 for the default profile and 10 for the large profile. Only after that wait does `s_ready_o` rise.
- R5: If none of ceil(WAIT_US/POLL_US) samples reads high, the load ends with error code 2. WAIT_US is 1506 for the default profile and 3000 for the large profile.
- R6: By default each byte leaves least significant bit first, so bit 0 goes out first and bit 7 last.
- R7: `data_o` changes only while `dclk_o` is low, and it is stable across each rising edge and high phase of `dclk_o`. Each phase lasts DCLK_HALF system clocks.
- R8: When `msb_first_i` is high at start, every byte of that load leaves bit 7 first.
- R9: If `status_n_i` is low after the last byte has been shifted, the load ends with error code 3 (load failed) and no trailing clocks are sent.
- R10: With HAS_DONE_PIN set, a low `conf_done_i` after the last byte ends the load with error code 3 and no trailing clocks. With HAS_DONE_PIN clear, that input is ignored.
- R11: After a clean check, eight more serial clocks are sent with `data_o` low. Then `done_o` goes high with `err_o` at 0 and busy drops.
- R12: A start with `partial_i` high sets error code 1 (invalid request) in the next cycle. The request line is not toggled and busy stays low.
- R13: `s_ready_o` is high only in the data phase while no byte is being shifted. `done_o` and `err_o` keep their values until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a load |
| partial_i | input | 1 | Start is a partial reconfiguration (rejected) |
| msb_first_i | input | 1 | Bytes of this load are sent bit 7 first |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Stream byte is the final one |
| s_ready_o | output | 1 | Loader accepts a stream byte |
| cfg_req_n_o | output | 1 | Active-low configuration request to target |
| status_n_i | input | 1 | Active-low target status (low = in reset or error) |
| conf_done_i | input | 1 | Target configuration-done indication |
| dclk_o | output | 1 | Serial clock to target |
| data_o | output | 1 | Serial data to target |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load completed cleanly |
| err_o | output | 2 | 0 none, 1 invalid request, 2 target not responding, 3 load failed |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that `partial_i` and `msb_first_i` are only meaningful alongside it. They also assume that the stream holds `s_data_i` and `s_last_i` steady while `s_valid_i` waits for `s_ready_o`. The stimulus drives every input at the falling system-clock edge, raises start for exactly one cycle, and keeps each byte on the stream until the handshake edge. The target model ties `status_n_i` to the request line during the pulse and releases it after a chosen delay. Faults are injected only after the last byte has been accepted.

// File: rtl/psc_pkg.sv
package psc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE,
      ST_POLL,
      ST_SETTLE,
      ST_STREAM,
      ST_CHECK,
      ST_TRAIL
   } psc_state_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_BAD_REQ = 2'd1,
      ERR_NO_RESP = 2'd2,
      ERR_LOAD    = 2'd3
   } psc_err_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/psc_serializer.sv
module psc_serializer #(
   parameter int HALF_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] byte_i,
   input  logic       msb_first_i,
   output logic       busy_o,
   output logic       fin_o,
   output logic       dclk_o,
   output logic       data_o
);

   localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [DW-1:0] DIV_TOP = DW'(HALF_CYC - 1);

   logic [7:0]    rev_byte;
   logic [7:0]    order;
   logic [7:0]    sreg_q;
   logic [2:0]    idx_q;
   logic [DW-1:0] div_q;
   logic          busy_q;
   logic          dclk_q;

   genvar g;
   generate
      for (g = 0; g < 8; g++) begin : g_rev
         assign rev_byte[g] = byte_i[7-g];
      end
   endgenerate

   assign order = msb_first_i ? rev_byte : byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         idx_q  <= '0;
         div_q  <= '0;
         busy_q <= 1'b0;
         dclk_q <= 1'b0;
      end else if (load_i && !busy_q) begin
         sreg_q <= order;
         idx_q  <= '0;
         div_q  <= DIV_TOP;
         busy_q <= 1'b1;
         dclk_q <= 1'b0;
      end else if (busy_q) begin
         if (div_q != '0) begin
            div_q <= div_q - DW'(1);
         end else begin
            div_q <= DIV_TOP;
            if (!dclk_q) begin
               dclk_q <= 1'b1;
            end else begin
               dclk_q <= 1'b0;
               if (idx_q == 3'd7) busy_q <= 1'b0;
               else               idx_q  <= idx_q + 3'd1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign dclk_o = dclk_q;
   assign data_o = busy_q & sreg_q[idx_q];
   assign fin_o  = busy_q && (div_q == '0) && dclk_q && (idx_q == 3'd7);

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
   import psc_pkg::*;
#(
   parameter int CLK_MHZ         = 50,
   parameter bit LARGE_DEVICE    = 1'b0,
   parameter bit HAS_DONE_PIN    = 1'b1,
   parameter int DCLK_HALF       = 2,
   parameter int REQ_US          = 2,
   parameter int POLL_US         = 268,
   parameter int WAIT_SMALL_US   = 1506,
   parameter int WAIT_LARGE_US   = 3000,
   parameter int SETTLE_SMALL_US = 2,
   parameter int SETTLE_LARGE_US = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       partial_i,
   input  logic       msb_first_i,
   input  logic       s_valid_i,
   input  logic [7:0] s_data_i,
   input  logic       s_last_i,
   output logic       s_ready_o,
   output logic       cfg_req_n_o,
   input  logic       status_n_i,
   input  logic       conf_done_i,
   output logic       dclk_o,
   output logic       data_o,
   output logic       busy_o,
   output logic       done_o,
   output logic [1:0] err_o
);

   localparam int WAIT_US    = LARGE_DEVICE ? WAIT_LARGE_US : WAIT_SMALL_US;
   localparam int SETTLE_US  = LARGE_DEVICE ? SETTLE_LARGE_US : SETTLE_SMALL_US;
   localparam int PULSE_CYC  = REQ_US * CLK_MHZ;
   localparam int POLL_CYC   = POLL_US * CLK_MHZ;
   localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
   localparam int NPOLL      = int'(ceil_div(WAIT_US, POLL_US));
   localparam int MAX_CYC    = int'(max3(PULSE_CYC, POLL_CYC, SETTLE_CYC));
   localparam int TW         = $clog2(MAX_CYC + 1);
   localparam int PW         = $clog2(NPOLL + 1);
   localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
   localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);
   localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
   localparam logic [PW-1:0] POLL_LAST = PW'(NPOLL - 1);

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be at least 1");
      end
      if (DCLK_HALF < 1) begin : g_bad_half
         $error("DCLK_HALF must be at least 1");
      end
      if (REQ_US < 1 || POLL_US < 1 || SETTLE_US < 1) begin : g_bad_time
         $error("timing parameters must be at least 1 us");
      end
      if (WAIT_US < POLL_US) begin : g_bad_wait
         $error("maximum wait must cover at least one poll");
      end
   endgenerate

   psc_state_e state_q, state_d;
   logic [PW-1:0] poll_q;
   logic          msb_q;
   logic          last_seen_q;
   logic          done_q;
   logic [1:0]    err_q;

   logic          t_load;
   logic [TW-1:0] t_val;
   logic          t_exp;
   logic          pc_clr, pc_inc;
   logic          clr_res, set_done, set_err;
   logic [1:0]    err_val;
   logic          take_byte, send_dummy;
   logic          ser_load, ser_busy, ser_fin;
   logic [7:0]    ser_byte;
   logic          done_ok;

   generate
      if (HAS_DONE_PIN) begin : g_done_pin
         assign done_ok = conf_done_i;
      end else begin : g_no_done_pin
         assign done_ok = 1'b1;
      end
   endgenerate

   psc_timer #(.W(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .expired_o  (t_exp)
   );

   assign s_ready_o = (state_q == ST_STREAM) && !ser_busy && !last_seen_q;
   assign take_byte = s_valid_i && s_ready_o;
   assign ser_load  = take_byte || send_dummy;
   assign ser_byte  = send_dummy ? 8'h00 : s_data_i;

   psc_serializer #(.HALF_CYC(DCLK_HALF)) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (ser_load),
      .byte_i      (ser_byte),
      .msb_first_i (msb_q),
      .busy_o      (ser_busy),
      .fin_o       (ser_fin),
      .dclk_o      (dclk_o),
      .data_o      (data_o)
   );

   always_comb begin
      state_d    = state_q;
      t_load     = 1'b0;
      t_val      = '0;
      pc_clr     = 1'b0;
      pc_inc     = 1'b0;
      clr_res    = 1'b0;
      set_done   = 1'b0;
      set_err    = 1'b0;
      err_val    = ERR_NONE;
      send_dummy = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               clr_res = 1'b1;
               if (partial_i) begin
                  set_err = 1'b1;
                  err_val = ERR_BAD_REQ;
               end else begin
                  state_d = ST_PULSE;
                  t_load  = 1'b1;
                  t_val   = PULSE_LD;
               end
            end
         end
         ST_PULSE: begin
            if (t_exp) begin
               if (status_n_i) begin
                  set_err = 1'b1;
                  err_val = ERR_NO_RESP;
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_POLL;
                  t_load  = 1'b1;
                  t_val   = POLL_LD;
                  pc_clr  = 1'b1;
               end
            end
         end
         ST_POLL: begin
            if (t_exp) begin
               if (status_n_i) begin
                  state_d = ST_SETTLE;
                  t_load  = 1'b1;
                  t_val   = SETTLE_LD;
               end else if (poll_q == POLL_LAST) begin
                  set_err = 1'b1;
                  err_val = ERR_NO_RESP;
                  state_d = ST_IDLE;
               end else begin
                  pc_inc  = 1'b1;
                  t_load  = 1'b1;
                  t_val   = POLL_LD;
               end
            end
         end
         ST_SETTLE: begin
            if (t_exp) state_d = ST_STREAM;
         end
         ST_STREAM: begin
            if (ser_fin && last_seen_q) state_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (!status_n_i || !done_ok) begin
               set_err = 1'b1;
               err_val = ERR_LOAD;
               state_d = ST_IDLE;
            end else begin
               send_dummy = 1'b1;
               state_d    = ST_TRAIL;
            end
         end
         ST_TRAIL: begin
            if (ser_fin) begin
               set_done = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         poll_q      <= '0;
         msb_q       <= 1'b0;
         last_seen_q <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= ERR_NONE;
      end else begin
         state_q <= state_d;
         if (pc_clr)      poll_q <= '0;
         else if (pc_inc) poll_q <= poll_q + PW'(1);
         if (state_q == ST_IDLE && start_i) begin
            msb_q       <= msb_first_i;
            last_seen_q <= 1'b0;
         end else if (take_byte && s_last_i) begin
            last_seen_q <= 1'b1;
         end
         if (clr_res) begin
            done_q <= 1'b0;
            err_q  <= ERR_NONE;
         end
         if (set_done) done_q <= 1'b1;
         if (set_err)  err_q  <= err_val;
      end
   end

   assign cfg_req_n_o = (state_q != ST_PULSE);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;

endmodule

// File: rtl/psc_checker.sv
module psc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       partial_i,
   input logic       busy_o,
   input logic       cfg_req_n_o,
   input logic       s_ready_o,
   input logic       dclk_o,
   input logic       data_o,
   input logic       done_o,
   input logic [1:0] err_o
);

   // R2: request line is low only during a load
   a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_req_n_o |-> busy_o);

   // R2: request line falls only right after a start
   a_r2_req_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_req_n_o) |-> $past(start_i));

   // R7: data held while the serial clock is high
   a_r7_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      dclk_o |-> $stable(data_o));

   // R11: success and error never reported together
   a_r11_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (err_o == 2'd0));

   // R12: partial request rejected without touching the request line
   a_r12_partial_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && partial_i && !busy_o) |=> (err_o == 2'd1 && cfg_req_n_o && !busy_o));

   // R13: stream ready only in the data phase
   a_r13_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (busy_o && cfg_req_n_o));

   // R13: idle loader is quiet on the link
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!dclk_o && !s_ready_o));

endmodule

bind ps_cfg_master psc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .partial_i   (partial_i),
   .busy_o      (busy_o),
   .cfg_req_n_o (cfg_req_n_o),
   .s_ready_o   (s_ready_o),
   .dclk_o      (dclk_o),
   .data_o      (data_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/ps_cfg_master_bench.sv
module ps_cfg_master_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MHZ        = 2;
   localparam int HALF       = 2;
   localparam int PULSE      = 2 * MHZ;
   localparam int POLL       = 268 * MHZ;
   localparam int SETTLE     = 10 * MHZ;
   localparam int NPOLL      = (3000 + 267) / 268;
   localparam int NVEC       = 6;
   localparam logic [8:0] VEC [NVEC] = '{9'h001, 9'h080, 9'h0A6, 9'h101, 9'h1B4, 9'h1FF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, partial_i = 1'b0, msb_first_i = 1'b0;
   logic s_valid_i = 1'b0, s_last_i = 1'b0;
   logic [7:0] s_data_i = 8'h00;
   logic s_ready_o, cfg_req_n_o, status_n_i, dclk_o, data_o, busy_o, done_o;
   logic conf_done_i = 1'b1;
   logic [1:0] err_o;

   logic tgt_resets = 1'b1;
   logic tgt_st = 1'b1;
   logic fault = 1'b0;
   int   rel_delay = 0;
   int   rel_cnt = 0;

   int n_chk = 0, n_fail = 0;
   int low_cnt = 0, bit_cnt = 0, rx_n = 0;
   logic ready_seen = 1'b0;
   logic prev_dclk = 1'b0;
   logic [7:0] cap = 8'h00;
   logic [7:0] rx [0:7];
   logic [7:0] tx [0:7];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign status_n_i = tgt_st & ~fault;

   ps_cfg_master #(.CLK_MHZ(MHZ), .LARGE_DEVICE(1'b1), .HAS_DONE_PIN(1'b1),
                   .DCLK_HALF(HALF)) u_ps_cfg_master (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
      .msb_first_i(msb_first_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
      .s_last_i(s_last_i), .s_ready_o(s_ready_o), .cfg_req_n_o(cfg_req_n_o),
      .status_n_i(status_n_i), .conf_done_i(conf_done_i), .dclk_o(dclk_o),
      .data_o(data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

   // target model and link monitor, both away from the active edge
   always @(negedge clk) begin
      if (!cfg_req_n_o) begin
         rel_cnt = 0;
         tgt_st  = !tgt_resets;
      end else if (!tgt_st && rel_cnt >= rel_delay) begin
         tgt_st = 1'b1;
      end else begin
         rel_cnt = rel_cnt + 1;
      end
      if (!cfg_req_n_o) low_cnt = low_cnt + 1;
      if (s_ready_o) ready_seen = 1'b1;
      if (dclk_o && !prev_dclk) begin
         cap = {data_o, cap[7:1]};
         bit_cnt = bit_cnt + 1;
         if (bit_cnt % 8 == 0) begin
            if (rx_n < 8) rx[rx_n] = cap;
            rx_n = rx_n + 1;
         end
      end
      prev_dclk = dclk_o;
   end

   function automatic logic [7:0] rev8(input logic [7:0] b);
      for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      low_cnt = 0; bit_cnt = 0; rx_n = 0; ready_seen = 1'b0;
   endtask

   task automatic pulse_start(input logic part, input logic msb);
      @(negedge clk);
      start_i = 1'b1; partial_i = part; msb_first_i = msb;
      @(negedge clk);
      start_i = 1'b0; partial_i = 1'b0; msb_first_i = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic last);
      s_valid_i = 1'b1; s_data_i = b; s_last_i = last;
      while (!s_ready_o) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      s_valid_i = 1'b0; s_last_i = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o) @(negedge clk);
   endtask

   task automatic do_load(input int n, input logic msb);
      clear_mon();
      pulse_start(1'b0, msb);
      for (int i = 0; i < n; i++) send_byte(tx[i], i == n - 1);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 req", {31'd0, cfg_req_n_o}, 32'd1);
      chk("R1 busy/done/dclk/ready", {28'd0, busy_o, done_o, dclk_o, s_ready_o}, 32'd0);
      chk("R1 err", {30'd0, err_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table: single-byte loads, R6 / R8 / R11
      for (int v = 0; v < NVEC; v++) begin
         tx[0] = VEC[v][7:0];
         do_load(1, VEC[v][8]);
         chk(VEC[v][8] ? "R8 msb-first byte" : "R6 lsb-first byte", {24'd0, rx[0]},
             {24'd0, VEC[v][8] ? rev8(VEC[v][7:0]) : VEC[v][7:0]});
         chk("R11 trailing zero byte", {24'd0, rx[1]}, 32'd0);
         chk("R11 bit count", bit_cnt, 32'd16);
         chk("R11 done/err", {29'd0, done_o, err_o}, 32'd4);
         chk("R2 pulse width", low_cnt, PULSE);
      end

      // multi-byte load, R6 and R7 with a stream of three
      tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'h0F;
      do_load(3, 1'b0);
      chk("R6 byte0", {24'd0, rx[0]}, 32'h5A);
      chk("R7 byte1", {24'd0, rx[1]}, 32'hC3);
      chk("R7 byte2", {24'd0, rx[2]}, 32'h0F);
      chk("R11 bits multi", bit_cnt, 32'd32);

      // R13 results held until next start
      repeat (40) @(negedge clk);
      chk("R13 done held", {29'd0, done_o, err_o}, 32'd4);
      chk("R13 ready idle", {31'd0, s_ready_o}, 32'd0);

      // R4 poll interval and settle, release seen on third poll
      rel_delay = 2 * POLL + 10;
      clear_mon();
      pulse_start(1'b0, 1'b0);
      chk("R13 start clears done", {30'd0, busy_o, done_o}, 32'd2);
      while (cfg_req_n_o) @(negedge clk);
      while (!cfg_req_n_o) @(negedge clk);
      n = 0;
      while (!s_ready_o) begin n++; @(negedge clk); end
      chk("R4 release-to-ready cycles", n, 3 * POLL + SETTLE);
      send_byte(8'h11, 1'b1);
      wait_idle();
      chk("R4 load ok", {29'd0, done_o, err_o}, 32'd4);

      // R5 target never ready
      rel_delay = 32'h7fffffff;
      clear_mon();
      pulse_start(1'b0, 1'b0);
      while (cfg_req_n_o) @(negedge clk);
      while (!cfg_req_n_o) @(negedge clk);
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
      chk("R5 wait cycles", n, NPOLL * POLL);
      chk("R5 err", {29'd0, done_o, err_o}, 32'd2);
      chk("R5 no ready", {31'd0, ready_seen}, 32'd0);
      rel_delay = 0;

      // R3 no reset seen
      tgt_resets = 1'b0;
      clear_mon();
      pulse_start(1'b0, 1'b0);
      wait_idle();
      chk("R3 err", {30'd0, err_o}, 32'd2);
      chk("R3 pulse width", low_cnt, PULSE);
      chk("R3 no ready", {31'd0, ready_seen}, 32'd0);
      tgt_resets = 1'b1;

      // R9 status low after last byte
      clear_mon();
      pulse_start(1'b0, 1'b0);
      send_byte(8'h77, 1'b1);
      fault = 1'b1;
      wait_idle();
      fault = 1'b0;
      chk("R9 err", {29'd0, done_o, err_o}, 32'd3);
      chk("R9 no trailing clocks", bit_cnt, 32'd8);

      // R10 done pin low
      conf_done_i = 1'b0;
      clear_mon();
      pulse_start(1'b0, 1'b0);
      send_byte(8'h99, 1'b1);
      wait_idle();
      conf_done_i = 1'b1;
      chk("R10 err", {29'd0, done_o, err_o}, 32'd3);
      chk("R10 no trailing clocks", bit_cnt, 32'd8);

      // R12 partial request
      clear_mon();
      pulse_start(1'b1, 1'b0);
      chk("R12 err", {30'd0, err_o}, 32'd1);
      chk("R12 busy", {31'd0, busy_o}, 32'd0);
      repeat (20) @(negedge clk);
      chk("R12 request untouched", low_cnt, 32'd0);
      chk("R13 err held", {30'd0, err_o}, 32'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule